// File: doc/BRIEF.md
# Descriptor-Table Register Loader

This block is the sequencing engine behind the two instructions that load a protected-mode system register from a 16-bit selector. One instruction loads the local descriptor table register and the other loads the task register. A pulse on `start` supplies the selector, the target register and the current privilege level. The block first screens the selector against the privilege level, the null rule, the table-indicator bit and the global table limit. It then fetches the 8-byte descriptor from the global descriptor table as two 32-bit reads through a plain request/ready memory port.

The block checks the descriptor's system flag, its type and its present bit. On success it latches the selector and both descriptor words into the cache of the chosen register and marks the cache valid. For the task register only, it also writes the second descriptor word back to memory with its busy bit set before it finishes.

The run ends with a one-cycle `done` pulse, or with a one-cycle `fault` pulse that carries a fault class and an error code. The surrounding execution unit turns that fault into the exception. Only 8-byte descriptors are handled.

Top module: `desc_table_reg_loader`

## Requirements
- R1: When `cur_priv` is not 0 at `start`, the run ends in a general-protection fault (`fault_kind`=0) with `fault_code`=0 and no memory access. This check comes before every other check.
- R2: For the local-table target (`target`=0), a null selector (bits 15:2 all zero) stores the selector in `ldt_sel`, clears `ldt_valid` and ends with `done` without any memory access.
- R3: For the task target (`target`=1), a null selector ends in a general-protection fault with code 0 and no memory access.
- R4: A non-null selector with bit 2 (table indicator) set ends in a general-protection fault whose code is the selector with bits 1:0 cleared, with no memory access.
- R5: If index*8+7 is greater than `gdt_limit`, where index is selector bits 15:3, the run ends in a general-protection fault with the masked selector as code and no memory access.
- R6: The descriptor is read as two words: first from `gdt_base`+index*8, then from `gdt_base`+index*8+4. Each request holds its address until `mem_ready`.
- R7: In the high word, bit 12 is the segment flag and bits 11:8 are the type. The local-table target accepts only flag 0 with type 2. The task target accepts only flag 0 with type 1 or type 9. Any other value gives a general-protection fault with the masked selector. The type check comes before the presence check.
- R8: If the descriptor type is accepted but high-word bit 15 (present) is 0, the run ends in a not-present fault (`fault_kind`=1) with the masked selector as code.
- R9: A successful load latches the selector, the low word and the high word into the target's cache and sets its valid flag. A local-table load ends with `done` after exactly two memory accesses.
- R10: A successful task load writes the high word ORed with 0x00000200 to `gdt_base`+index*8+4 as a third access, and then ends with `done`.
- R11: `done` and `fault` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (sampled when idle) |
| target | input | 1 | 0 = local table register, 1 = task register |
| cur_priv | input | 2 | Current privilege level |
| selector | input | 16 | Selector to load |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table limit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access complete |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault pulse |
| fault_kind | output | 1 | 0 = general protection, 1 = not present |
| fault_code | output | 16 | Error code accompanying fault |
| ldt_sel | output | 16 | Local table register selector |
| ldt_valid | output | 1 | Local table cache valid |
| ldt_lo | output | 32 | Local table descriptor low word |
| ldt_hi | output | 32 | Local table descriptor high word |
| tr_sel | output | 16 | Task register selector |
| tr_valid | output | 1 | Task register cache valid |
| tr_lo | output | 32 | Task descriptor low word |
| tr_hi | output | 32 | Task descriptor high word |

## Verification
A wrong state in the sequencer would show up as a wrong number of accesses, or a wrong address, in the same run that caused it. Examples are a skipped read, a busy write-back issued for the local-table target, or an access made after a screening fault. The bench counts accesses and records their addresses for each run. A wrong choice of which check comes first would show as a wrong fault class or code on the very pulse that ends the run. A cache latched into the wrong bank would be visible on the register outputs as soon as `done` rises. The busy write-back also changes the table, so a later load of the same selector must then fault, and the sweeps exercise that case.

// File: rtl/ldtr_pkg.sv
// Shared types and field positions for the descriptor-table register loader.
// Assumes the 8-byte legacy descriptor layout: the high word holds the
// present bit, the segment flag and the 4-bit type.
package ldtr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_LO,
        ST_READ_HI,
        ST_CHECK,
        ST_WRITE_BUSY,
        ST_DONE,
        ST_FAULT
    } ld_state_t;

    localparam logic FK_GP = 1'b0;
    localparam logic FK_NP = 1'b1;

    localparam int HI_PRESENT_BIT = 15;
    localparam int HI_SEGFLAG_BIT = 12;
    localparam int HI_TYPE_LSB    = 8;
    localparam int HI_BUSY_BIT    = 9;

    localparam logic [3:0] TY_LOCAL_TABLE = 4'h2;
    localparam logic [3:0] TY_TASK_16     = 4'h1;
    localparam logic [3:0] TY_TASK_32     = 4'h9;

endpackage

// File: rtl/sel_precheck.sv
// Combinational screening of a selector before any memory access.
// Order: privilege, null, table indicator, table limit.
// Assumes bit 2 is the table indicator and bits SEL_W-1:3 the index.
module sel_precheck #(
    parameter int SEL_W  = 16,
    parameter int PRIV_W = 2,
    parameter int LIM_W  = 16
) (
    input  logic              is_task,
    input  logic [PRIV_W-1:0] priv,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LIM_W-1:0]  limit,
    output logic              reject,
    output logic              null_ldt,
    output logic [SEL_W-1:0]  code
);
    localparam int IDX_W = SEL_W - 3;
    localparam int CMP_W = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;

    logic [IDX_W-1:0] idx;
    logic [CMP_W-1:0] span_end;
    logic [CMP_W-1:0] lim_ext;
    logic [SEL_W-1:0] masked;
    logic             is_null;

    assign idx      = sel[SEL_W-1:3];
    assign span_end = CMP_W'({idx, 3'b111});
    assign lim_ext  = CMP_W'(limit);
    assign masked   = {sel[SEL_W-1:2], 2'b00};
    assign is_null  = (sel[SEL_W-1:2] == '0);

    // Purpose: pick the first failing screen in priority order.
    always_comb begin
        reject   = 1'b0;
        null_ldt = 1'b0;
        code     = '0;
        if (priv != '0) begin
            reject = 1'b1;
        end else if (is_null) begin
            if (is_task) reject = 1'b1;
            else         null_ldt = 1'b1;
        end else if (sel[2]) begin
            reject = 1'b1;
            code   = masked;
        end else if (span_end > lim_ext) begin
            reject = 1'b1;
            code   = masked;
        end
    end
endmodule

// File: rtl/desc_validate.sv
// Combinational validation of a fetched descriptor high word against the
// target register. Type is checked before presence.
module desc_validate #(
    parameter int DATA_W = 32
) (
    input  logic              is_task,
    input  logic [DATA_W-1:0] hi_word,
    output logic              reject,
    output logic              kind
);
    import ldtr_pkg::*;

    logic [3:0] dtype;
    logic       segflag;
    logic       present;
    logic       type_ok;

    assign dtype   = hi_word[HI_TYPE_LSB +: 4];
    assign segflag = hi_word[HI_SEGFLAG_BIT];
    assign present = hi_word[HI_PRESENT_BIT];

    // Purpose: decide whether the system type suits the target register.
    always_comb begin
        if (segflag) type_ok = 1'b0;
        else if (is_task) type_ok = (dtype == TY_TASK_16) || (dtype == TY_TASK_32);
        else type_ok = (dtype == TY_LOCAL_TABLE);
    end

    // Purpose: map the failing check to a fault class.
    always_comb begin
        reject = 1'b0;
        kind   = FK_GP;
        if (!type_ok) begin
            reject = 1'b1;
        end else if (!present) begin
            reject = 1'b1;
            kind   = FK_NP;
        end
    end
endmodule

// File: rtl/cache_bank.sv
// Holding register for one system register: selector, descriptor words and
// a valid flag. A load sets valid; an invalidate stores only the selector.
module cache_bank #(
    parameter int SEL_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inval,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [DATA_W-1:0] lo_in,
    input  logic [DATA_W-1:0] hi_in,
    output logic [SEL_W-1:0]  sel_out,
    output logic              valid_out,
    output logic [DATA_W-1:0] lo_out,
    output logic [DATA_W-1:0] hi_out
);
    // Purpose: update the cached register contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_out   <= '0;
            valid_out <= 1'b0;
            lo_out    <= '0;
            hi_out    <= '0;
        end else if (load) begin
            sel_out   <= sel_in;
            valid_out <= 1'b1;
            lo_out    <= lo_in;
            hi_out    <= hi_in;
        end else if (inval) begin
            sel_out   <= sel_in;
            valid_out <= 1'b0;
        end
    end
endmodule

// File: rtl/desc_table_reg_loader.sv
// Top of the loader. Screens the selector, fetches the descriptor in two
// reads, validates it, latches the target cache and, for the task target,
// writes the busy bit back. Assumes gdt_base and gdt_limit stay stable
// during a run and that start is only honoured in the idle state.
module desc_table_reg_loader #(
    parameter int SEL_W  = 16,
    parameter int PRIV_W = 2,
    parameter int LIM_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              target,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [SEL_W-1:0]  selector,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              fault,
    output logic              fault_kind,
    output logic [SEL_W-1:0]  fault_code,
    output logic [SEL_W-1:0]  ldt_sel,
    output logic              ldt_valid,
    output logic [DATA_W-1:0] ldt_lo,
    output logic [DATA_W-1:0] ldt_hi,
    output logic [SEL_W-1:0]  tr_sel,
    output logic              tr_valid,
    output logic [DATA_W-1:0] tr_lo,
    output logic [DATA_W-1:0] tr_hi
);
    import ldtr_pkg::*;

    localparam int NUM_BANKS = 2;
    localparam int IDX_W     = SEL_W - 3;
    localparam int HALF_OFS  = DATA_W / 8;

    ld_state_t         state;
    logic              tgt_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [SEL_W-1:0]  code_q;
    logic              kind_q;

    logic              pre_reject;
    logic              pre_null;
    logic [SEL_W-1:0]  pre_code;
    logic              chk_reject;
    logic              chk_kind;

    logic [ADDR_W-1:0] entry_addr;
    logic [SEL_W-1:0]  bank_sel_in;
    logic              load_ok;

    logic [NUM_BANKS-1:0] bank_load;
    logic [NUM_BANKS-1:0] bank_inval;
    logic [SEL_W-1:0]     bank_sel  [NUM_BANKS];
    logic                 bank_vld  [NUM_BANKS];
    logic [DATA_W-1:0]    bank_lo   [NUM_BANKS];
    logic [DATA_W-1:0]    bank_hi   [NUM_BANKS];

    sel_precheck #(.SEL_W(SEL_W), .PRIV_W(PRIV_W), .LIM_W(LIM_W)) u_pre (
        .is_task  (target),
        .priv     (cur_priv),
        .sel      (selector),
        .limit    (gdt_limit),
        .reject   (pre_reject),
        .null_ldt (pre_null),
        .code     (pre_code)
    );

    desc_validate #(.DATA_W(DATA_W)) u_val (
        .is_task (tgt_q),
        .hi_word (hi_q),
        .reject  (chk_reject),
        .kind    (chk_kind)
    );

    // Purpose: compute the byte address of the descriptor entry.
    assign entry_addr = gdt_base + ADDR_W'({sel_q[SEL_W-1:3], 3'b000});

    // Purpose: drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_addr;
        mem_wdata = hi_q | (DATA_W'(1) << HI_BUSY_BIT);
        case (state)
            ST_READ_LO:    mem_req = 1'b1;
            ST_READ_HI: begin
                mem_req  = 1'b1;
                mem_addr = entry_addr + ADDR_W'(HALF_OFS);
            end
            ST_WRITE_BUSY: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = entry_addr + ADDR_W'(HALF_OFS);
            end
            default: ;
        endcase
    end

    // Purpose: sequence screening, fetch, validation and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tgt_q  <= 1'b0;
            sel_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            code_q <= '0;
            kind_q <= FK_GP;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        tgt_q <= target;
                        sel_q <= selector;
                        if (pre_reject) begin
                            code_q <= pre_code;
                            kind_q <= FK_GP;
                            state  <= ST_FAULT;
                        end else if (pre_null) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_READ_LO;
                        end
                    end
                end
                ST_READ_LO: begin
                    if (mem_ready) begin
                        lo_q  <= mem_rdata;
                        state <= ST_READ_HI;
                    end
                end
                ST_READ_HI: begin
                    if (mem_ready) begin
                        hi_q  <= mem_rdata;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_reject) begin
                        code_q <= {sel_q[SEL_W-1:2], 2'b00};
                        kind_q <= chk_kind;
                        state  <= ST_FAULT;
                    end else if (tgt_q) begin
                        state <= ST_WRITE_BUSY;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_WRITE_BUSY: begin
                    if (mem_ready) state <= ST_DONE;
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign load_ok     = (state == ST_CHECK) && !chk_reject;
    assign bank_sel_in = (state == ST_IDLE) ? selector : sel_q;

    // Purpose: one cache bank per target register.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_load[g]  = load_ok && (tgt_q == g[0]);
        assign bank_inval[g] = (state == ST_IDLE) && start && !pre_reject
                               && pre_null && (target == g[0]);
        cache_bank #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (bank_load[g]),
            .inval     (bank_inval[g]),
            .sel_in    (bank_sel_in),
            .lo_in     (lo_q),
            .hi_in     (hi_q),
            .sel_out   (bank_sel[g]),
            .valid_out (bank_vld[g]),
            .lo_out    (bank_lo[g]),
            .hi_out    (bank_hi[g])
        );
    end

    assign ldt_sel    = bank_sel[0];
    assign ldt_valid  = bank_vld[0];
    assign ldt_lo     = bank_lo[0];
    assign ldt_hi     = bank_hi[0];
    assign tr_sel     = bank_sel[1];
    assign tr_valid   = bank_vld[1];
    assign tr_lo      = bank_lo[1];
    assign tr_hi      = bank_hi[1];

    assign done       = (state == ST_DONE);
    assign fault      = (state == ST_FAULT);
    assign fault_kind = kind_q;
    assign fault_code = code_q;
endmodule

// File: rtl/desc_table_reg_loader_chk.sv
// Assertion checker for the loader, attached by bind below.
module desc_table_reg_loader_chk #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fault,
    input logic [SEL_W-1:0]  fault_code,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              ldt_valid,
    input logic [SEL_W-1:0]  ldt_sel,
    input logic              tgt_q
);
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R4, R5, R8: every nonzero error code has its low two bits cleared
    assert_code_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code[1:0] == 2'b00));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[9] && tgt_q && (mem_addr[2:0] == 3'd4)));

    assert_ldt_null_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldt_valid) |-> (ldt_sel[SEL_W-1:2] == '0));
endmodule

bind desc_table_reg_loader desc_table_reg_loader_chk #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .ldt_valid  (ldt_valid),
    .ldt_sel    (ldt_sel),
    .tgt_q      (tgt_q)
);

// File: tb/desc_table_reg_loader_tb.sv
module desc_table_reg_loader_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0000_0100;
    localparam logic [15:0] LIMIT      = 16'h003F;
    localparam int          ENTRIES    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        target = 1'b0;
    logic [1:0]  cur_priv = 2'd0;
    logic [15:0] selector = 16'h0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault, fault_kind;
    logic [15:0] fault_code, ldt_sel, tr_sel;
    logic        ldt_valid, tr_valid;
    logic [31:0] ldt_lo, ldt_hi, tr_lo, tr_hi;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_table_reg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .cur_priv(cur_priv), .selector(selector), .gdt_base(BASE),
        .gdt_limit(LIMIT), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .fault(fault),
        .fault_kind(fault_kind), .fault_code(fault_code),
        .ldt_sel(ldt_sel), .ldt_valid(ldt_valid), .ldt_lo(ldt_lo),
        .ldt_hi(ldt_hi), .tr_sel(tr_sel), .tr_valid(tr_valid),
        .tr_lo(tr_lo), .tr_hi(tr_hi)
    );

    // Memory model: one-cycle ready, preload port for the bench
    logic [31:0] gmem [0:2*ENTRIES-1];
    logic        ready_q = 1'b0;
    logic [31:0] rdata_q = 32'h0;
    logic        pl_we = 1'b0;
    logic [3:0]  pl_word = 4'h0;
    logic [31:0] pl_data = 32'h0;
    int          acc_total = 0;
    logic [31:0] acc_addr [0:3];
    logic [31:0] ofs;
    logic [3:0]  word;

    assign ofs       = mem_addr - BASE;
    assign word      = ofs[5:2];
    assign mem_ready = ready_q;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (pl_we) gmem[pl_word] <= pl_data;
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (mem_req && !ready_q) begin
            ready_q <= 1'b1;
            if (mem_we) gmem[word] <= mem_wdata;
            else        rdata_q    <= gmem[word];
            acc_addr[acc_total % 4] <= mem_addr;
        end else begin
            ready_q <= 1'b0;
        end
        if (mem_req && ready_q) acc_total <= acc_total + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic set_word(input int w, input logic [31:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_word = 4'(w); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    // res: 0 done, 1 general protection, 2 not present
    task automatic predict(input bit tgt, input logic [1:0] pr, input logic [15:0] s,
                           output int res, output logic [15:0] code,
                           output int acc, output string req);
        int idx = int'(s[15:3]);
        logic [15:0] msk = {s[15:2], 2'b00};
        logic [31:0] hi;
        bit tok;
        res = 1; code = 16'h0; acc = 0;
        if (pr != 2'd0) begin
            req = "R1";
        end else if (s[15:2] == 14'h0) begin
            if (!tgt) begin res = 0; req = "R2"; end
            else req = "R3";
        end else if (s[2]) begin
            code = msk; req = "R4";
        end else if (idx * 8 + 7 > int'(LIMIT)) begin
            code = msk; req = "R5";
        end else begin
            hi  = gmem[idx*2+1];
            acc = 2;
            if (tgt) tok = !hi[12] && (hi[11:8] == 4'h1 || hi[11:8] == 4'h9);
            else     tok = !hi[12] && (hi[11:8] == 4'h2);
            if (!tok) begin code = msk; req = "R7"; end
            else if (!hi[15]) begin res = 2; code = msk; req = "R8"; end
            else begin res = 0; acc = tgt ? 3 : 2; req = tgt ? "R10" : "R9"; end
        end
    endtask

    task automatic run_one(input bit tgt, input logic [1:0] pr, input logic [15:0] s);
        int res, acc, a0, n, idx, act_res;
        logic [15:0] code;
        string req;
        logic [31:0] lo0, hi0;
        predict(tgt, pr, s, res, code, acc, req);
        idx = int'(s[15:3]);
        if (idx < ENTRIES) begin
            lo0 = gmem[idx*2]; hi0 = gmem[idx*2+1];
        end else begin
            lo0 = 32'h0; hi0 = 32'h0;
        end
        a0 = acc_total;
        @(negedge clk);
        start = 1'b1; target = tgt; cur_priv = pr; selector = s;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!(done || fault) && n < 50) begin
            @(negedge clk);
            n++;
        end
        act_res = done ? 0 : (fault ? (fault_kind ? 2 : 1) : 3);
        check(act_res == res, req, "outcome", 32'(act_res), 32'(res));
        if (res != 0)
            check(fault_code == code, req, "fault code", 32'(fault_code), 32'(code));
        check(acc_total - a0 == acc, req, "access count", 32'(acc_total - a0), 32'(acc));
        if (acc >= 2) begin
            check(acc_addr[a0 % 4] == BASE + 32'(idx * 8), "R6", "first address",
                  acc_addr[a0 % 4], BASE + 32'(idx * 8));
            check(acc_addr[(a0 + 1) % 4] == BASE + 32'(idx * 8 + 4), "R6", "second address",
                  acc_addr[(a0 + 1) % 4], BASE + 32'(idx * 8 + 4));
        end
        if (res == 0 && req == "R2") begin
            check(ldt_sel == s && !ldt_valid, "R2", "null cache",
                  {15'h0, ldt_valid, ldt_sel}, {16'h0, s});
        end else if (res == 0 && !tgt) begin
            check(ldt_sel == s && ldt_valid && ldt_lo == lo0 && ldt_hi == hi0, "R9",
                  "local cache", ldt_hi, hi0);
        end else if (res == 0) begin
            check(tr_sel == s && tr_valid && tr_lo == lo0 && tr_hi == hi0, "R9",
                  "task cache", tr_hi, hi0);
            check(gmem[idx*2+1] == (hi0 | 32'h200), "R10", "busy write-back",
                  gmem[idx*2+1], hi0 | 32'h200);
            check(acc_addr[(a0 + 2) % 4] == BASE + 32'(idx * 8 + 4), "R10", "write address",
                  acc_addr[(a0 + 2) % 4], BASE + 32'(idx * 8 + 4));
        end
        @(negedge clk);
        check(!done && !fault, "R11", "pulse width", {30'h0, done, fault}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !fault && !mem_req, "R11", "reset outputs",
              {29'h0, done, fault, mem_req}, 32'h0);
        check(!ldt_valid && !tr_valid, "R9", "reset valid",
              {30'h0, ldt_valid, tr_valid}, 32'h0);

        for (int i = 0; i < ENTRIES; i++) begin
            set_word(2*i, 32'h00A0_0000 | 32'(i * 32'h0101));
            set_word(2*i + 1, ((i % 2) != 0 ? 32'h0000_8200 : 32'h0000_8900) | 32'(i << 16));
        end

        // R1: privilege screen comes first, also over null selectors
        for (int pr = 1; pr < 4; pr++)
            for (int t = 0; t < 2; t++) begin
                run_one(t[0], 2'(pr), 16'h000B);
                run_one(t[0], 2'(pr), 16'h0000);
            end

        // Selector sweep: index 0..9, table indicator, requested level
        for (int t = 0; t < 2; t++)
            for (int ix = 0; ix < 10; ix++)
                for (int ti = 0; ti < 2; ti++)
                    for (int rp = 0; rp < 4; rp++)
                        run_one(t[0], 2'd0, 16'((ix << 3) | (ti << 2) | rp));

        // Type, flag and presence sweep at index 5
        for (int t = 0; t < 2; t++)
            for (int sf = 0; sf < 2; sf++)
                for (int pb = 0; pb < 2; pb++)
                    for (int ty = 0; ty < 16; ty++) begin
                        set_word(10, 32'h1234_0000 | 32'(ty));
                        set_word(11, 32'h0040_0000 | 32'(pb << 15) | 32'(sf << 12) | 32'(ty << 8));
                        run_one(t[0], 2'd0, 16'h002A);
                    end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule